// File: doc/BRIEF.md
# Multiplexed External Data Bus Cycle Generator

This block runs the external data memory cycles of an 8-bit controller whose low address byte and data byte share one set of pins. Each cycle lasts twelve clock periods, and one clock period stands for one oscillator period. Every strobe edge falls on a whole clock boundary at a fixed offset inside the cycle.

On the internal side a client raises `req` while `ready` is high, together with a 16-bit address, a direction flag and a write byte. For a read, the byte captured from the bus comes back on `rdata` and is valid while `done` is high. `done` is a single-clock pulse in the last period of the cycle.

On the external side the block drives the following pins:
- the address latch strobe `ale`;
- the active-low read and write strobes;
- a fixed high-address byte;
- the shared low port. `ad_out` carries the outgoing byte, `ad_oe` enables its driver, and `ad_in` carries the incoming byte.

Top module: `xbus_cycle_gen`

## Requirements
- R1: After reset and between cycles: `ale` is 0, `rd_n` and `wr_n` are 1, `done` is 0 and `ready` is 1. `ad_oe` is 0, except during the one write-hold period of R8.
- R2: A request is accepted at the clock edge where `req` and `ready` are both high. Phase 0 is the period that follows this edge, and the cycle runs through phases 0 to 11. `ale` is 1 in phases 0 and 1 and 0 in every other phase.
- R3: The low address byte appears on `ad_out` with `ad_oe` = 1 from phase 1. This is one period before `ale` falls. On a write it stays through phase 3; on a read it stays through phase 4.
- R4: The strobe falls at the start of phase 5. This is three periods after `ale` falls and four periods after the low address is first driven. A read lowers only `rd_n` (`we` = 0) and a write lowers only `wr_n` (`we` = 1).
- R5: The strobe stays low for exactly six periods, phases 5 to 10, and rises at the start of phase 11.
- R6: On a read, `ad_oe` is 0 from phase 5, the period in which `rd_n` falls. The value on `ad_in` during phase 10 (the last period with `rd_n` low) is sampled as `rd_n` rises. It appears on `rdata` in phase 11.
- R7: On a write, the write byte is driven on `ad_out` with `ad_oe` = 1 from phase 4, one period before `wr_n` falls. It stays through phase 11, which makes seven periods before `wr_n` rises.
- R8: On a write, the byte stays driven for two periods after `wr_n` rises: phase 11 and the following period. This holds whether the following period is idle or phase 0 of a new cycle.
- R9: `ready` is 1 in phase 11. A request taken there starts the next cycle directly, so the next `ale` rises one period after the strobe rises.
- R10: `done` is 1 only in phase 11, for one clock.
- R11: `addr_hi` carries bits 15:8 of the accepted address. It changes only at the clock edge that accepts a request.
- R12: A request raised while `ready` is 0 is ignored. The current cycle, `addr_hi` and the bus outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Cycle request, taken when `ready` is high |
| we | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write byte |
| ready | output | 1 | Block can take a request this clock |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Byte captured on the last read |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Outgoing byte on the shared low port |
| ad_oe | output | 1 | Driver enable for the shared low port |
| ad_in | input | 8 | Incoming byte from the shared low port |

## Verification
The assertions assume that `req` is sampled only at rising clock edges. They also assume that nothing other than an accepted request changes the high address byte. The bench drives every input on the falling edge, so each request is seen whole at exactly one rising edge.

The bench drives `ad_in` with a wrong value in every phase except phase 10, so a capture in the wrong period yields a wrong `rdata`. It also raises a stray request with a flipped address during phase 3, in which the request must be refused.

// File: rtl/xbus_cycle_gen.sv
`timescale 1ns/1ps
module xbus_cycle_gen #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int ALE_W = 2,
  parameter int STB_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);
  localparam int ADDR_ON_I = ALE_W - 1;
  localparam int STB_ON_I  = ALE_W + 3;
  localparam int DATA_ON_I = STB_ON_I - 1;
  localparam int LAST_I    = STB_ON_I + STB_W;
  localparam int PW        = $clog2(LAST_I + 1);

  localparam logic [PW-1:0] P_ALE_END = PW'(ALE_W);
  localparam logic [PW-1:0] P_ADDR_ON = PW'(ADDR_ON_I);
  localparam logic [PW-1:0] P_DATA_ON = PW'(DATA_ON_I);
  localparam logic [PW-1:0] P_STB_ON  = PW'(STB_ON_I);
  localparam logic [PW-1:0] P_LAST    = PW'(LAST_I);
  localparam logic [PW-1:0] P_SAMPLE  = PW'(LAST_I - 1);

  logic          busy, we_q, hold_q;
  logic [PW-1:0] ph;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q, hold_d, rd_q;
  logic          last, take, in_addr, in_data, stb;

  assign last  = busy && (ph == P_LAST);
  assign ready = !busy || last;
  assign take  = req && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= '0;
      we_q   <= 1'b0;
      a_q    <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      hold_q <= 1'b0;
      hold_d <= '0;
    end else begin
      if (take) begin
        busy <= 1'b1;
        ph   <= '0;
        a_q  <= addr;
        we_q <= we;
        wd_q <= wdata;
      end else if (last) begin
        busy <= 1'b0;
        ph   <= '0;
      end else if (busy) begin
        ph <= ph + 1'b1;
      end
      if (busy && !we_q && ph == P_SAMPLE) rd_q <= ad_in;
      hold_q <= last && we_q;
      if (last && we_q) hold_d <= wd_q;
    end
  end

  assign ale     = busy && (ph < P_ALE_END);
  assign in_addr = busy && (ph >= P_ADDR_ON) && (ph < (we_q ? P_DATA_ON : P_STB_ON));
  assign in_data = busy && we_q && (ph >= P_DATA_ON);
  assign stb     = busy && (ph >= P_STB_ON) && (ph < P_LAST);

  assign rd_n    = !(stb && !we_q);
  assign wr_n    = !(stb && we_q);
  assign ad_oe   = in_addr || in_data || hold_q;
  assign ad_out  = in_addr ? a_q[DW-1:0] : (in_data ? wd_q : hold_d);
  assign addr_hi = a_q[AW-1:DW];
  assign done    = last;
  assign rdata   = rd_q;
endmodule

module xbus_cycle_gen_chk #(
  parameter int HW    = 8,
  parameter int STB_W = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          ready,
  input logic          done,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ad_oe,
  input logic [HW-1:0] addr_hi
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               low_cnt <= '0;
    else if (!rd_n || !wr_n)  low_cnt <= low_cnt + 1'b1;
    else                      low_cnt <= '0;
  end

  AST_ALE_MIN:     assert property (@(posedge clk) disable iff (!rst_n) $rose(ale) |=> ale); // R2
  AST_ALE_MAX:     assert property (@(posedge clk) disable iff (!rst_n) (ale && $past(ale)) |=> !ale); // R2
  AST_ONE_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R4
  AST_STROBE_LEN:  assert property (@(posedge clk) disable iff (!rst_n) (rd_n && wr_n && low_cnt != 0) |-> low_cnt == 8'(STB_W)); // R5
  AST_STROBE_MAX:  assert property (@(posedge clk) disable iff (!rst_n) low_cnt <= 8'(STB_W)); // R5
  AST_RD_FLOAT:    assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R6
  AST_WR_DRIVEN:   assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe); // R7
  AST_ALE_GAP:     assert property (@(posedge clk) disable iff (!rst_n) $rose(ale) |-> $past(rd_n && wr_n)); // R9
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_HI_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(req && ready)) |-> $stable(addr_hi)); // R11
  AST_NO_ALE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ready && !done) |-> !ale); // R1
endmodule

bind xbus_cycle_gen xbus_cycle_gen_chk #(.HW(AW - DW), .STB_W(STB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .done(done),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .addr_hi(addr_hi)
);

// File: tb/xbus_cycle_gen_test.sv
`timescale 1ns/1ps
module xbus_cycle_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, ad_in = '0;
  logic        ready, done, ale, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, addr_hi, ad_out;

  int checks = 0, errors = 0;
  logic       prev_hold = 1'b0;
  logic [7:0] prev_d = '0;

  always #4 clk = ~clk;

  xbus_cycle_gen uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_step();
    @(negedge clk);
    chk("R1 ale idle", ale, 0);
    chk("R1 rd_n idle", rd_n, 1);
    chk("R1 wr_n idle", wr_n, 1);
    chk("R1 ready idle", ready, 1);
    chk("R1 done idle", done, 0);
    chk("R8 hold oe idle", ad_oe, prev_hold);
    if (prev_hold) chk("R8 hold data idle", ad_out, prev_d);
    prev_hold = 1'b0;
  endtask

  task automatic run(input logic w, input logic [15:0] a, input logic [7:0] d, input logic [7:0] rv);
    logic [7:0] hi_exp;
    hi_exp = a[15:8];
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = ~w; addr = ~a; wdata = ~d;
    for (int p = 0; p < 12; p++) begin
      logic e_addr, e_data, e_stb, e_oe;
      if (p > 0) @(negedge clk);
      ad_in = (p == 10) ? rv : ~rv;
      if (p == 3) begin req = 1'b1; addr = ~a; we = ~w; end
      if (p == 4) req = 1'b0;
      e_addr = (p >= 1) && (p < (w ? 4 : 5));
      e_data = w && (p >= 4);
      e_stb  = (p >= 5) && (p < 11);
      e_oe   = e_addr || e_data || (p == 0 && prev_hold);
      chk("R2 ale phase", ale, (p < 2) ? 1 : 0);
      chk("R4 R5 rd_n phase", rd_n, (e_stb && !w) ? 0 : 1);
      chk("R4 R5 wr_n phase", wr_n, (e_stb && w) ? 0 : 1);
      chk(w ? "R7 oe phase" : "R6 oe phase", ad_oe, e_oe);
      if (e_addr) chk("R3 low address", ad_out, a[7:0]);
      if (e_data) chk("R7 write data", ad_out, d);
      if (p == 0 && prev_hold) chk("R8 hold into next cycle", ad_out, prev_d);
      chk("R11 R12 addr_hi", addr_hi, hi_exp);
      chk("R10 done", done, (p == 11) ? 1 : 0);
      chk("R9 R12 ready", ready, (p == 11) ? 1 : 0);
      if (p == 11 && !w) chk("R6 read data", rdata, rv);
    end
    prev_hold = w;
    prev_d = d;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ale", ale, 0);
    chk("R1 reset rd_n", rd_n, 1);
    chk("R1 reset wr_n", wr_n, 1);
    chk("R1 reset oe", ad_oe, 0);
    chk("R1 reset ready", ready, 1);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    idle_step();
    run(1'b0, 16'h0000, 8'h00, 8'hFF);
    idle_step();
    run(1'b1, 16'hFFFF, 8'hA5, 8'h00);
    idle_step();
    idle_step();
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a;
      a = 16'((i * 16'h0F1D) ^ 16'hA55A);
      run(i[0] ^ i[2], a, 8'(i * 37 + 5), 8'(~a[7:0] ^ 8'(i)));
      if (i % 3 == 2) begin
        idle_step();
        idle_step();
      end
    end
    idle_step();
    idle_step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule